// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only serial port that loads a bank of four 6-bit control registers. A host frames each transfer with an active-low latch line. While the line is low, bits are shifted in on rising edges of a slow serial clock, most significant bit first. When the latch line returns high, the most recent byte is decoded. Its two low bits pick the target register and its six high bits become that register's new value.

The serial clock, data and latch lines are asynchronous to the system clock. They pass through a synchronizer chain and their edges are detected in the system clock domain. A conversion-busy input blocks any commit while it is high, so the settings cannot change in the middle of an operation. An asynchronous reset restores the per-register default values at once.

Top module: `cfg_serial_port`

## Requirements
- R1: While `arst` is high, every output register holds its default value (parameters `DEF0`..`DEF3`), without waiting for a clock edge.
- R2: While `ser_latch_n` is low, each rising edge of `ser_clk` shifts `ser_dat` into the byte, MSB first. Byte bits [1:0] are the register address and bits [7:2] are the register data.
- R3: A rising edge of `ser_latch_n` writes the data field into the addressed register only (address 0 to `cfg0`, up to address 3 to `cfg3`). The other three registers keep their values.
- R4: When more than eight bits are shifted before the latch edge, only the last eight are used.
- R5: A latch edge that follows fewer than eight counted serial clock edges since the previous latch edge writes no register.
- R6: A latch edge seen while `conv_busy` is high writes no register.
- R7: Rising edges of `ser_clk` while `ser_latch_n` is high are neither shifted nor counted.
- R8: With the default two synchronizer stages, an input edge first sampled at system clock edge n takes effect at edge n+2. A committed value therefore appears on the outputs after the third system clock edge that sees the latch line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst | input | 1 | Asynchronous reset, active high |
| ser_clk | input | 1 | Serial configuration clock (asynchronous) |
| ser_dat | input | 1 | Serial configuration data (asynchronous) |
| ser_latch_n | input | 1 | Enable while low, commit on rising edge |
| conv_busy | input | 1 | Conversion in progress; blocks commits |
| cfg0 | output | 6 | Register at address 0 |
| cfg1 | output | 6 | Register at address 1 |
| cfg2 | output | 6 | Register at address 2 |
| cfg3 | output | 6 | Register at address 3 |

## Verification
The assertions assume that each level on the serial lines lasts longer than the synchronizer chain. They also assume that `conv_busy` is synchronous to `clk`, and that a register changes only on a qualified latch edge. The stimulus holds every serial clock phase and data bit for three system clocks, drives all inputs on the falling system edge, and never moves the serial clock and latch lines in the same cycle. A behavioural reference fed from queues of sampled inputs is compared with the outputs on every cycle. This covers the exact commit cycle as well as the over-length, short, busy and idle-clock patterns.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [5:0]  DEF0 = 6'h01,
  parameter logic [5:0]  DEF1 = 6'h01,
  parameter logic [5:0]  DEF2 = 6'h20,
  parameter logic [5:0]  DEF3 = 6'h00
) (
  input  logic       clk,
  input  logic       arst,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ser_latch_n,
  input  logic       conv_busy,
  output logic [5:0] cfg0,
  output logic [5:0] cfg1,
  output logic [5:0] cfg2,
  output logic [5:0] cfg3
);

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sc_q, sd_q, sl_q;
  logic                   sc_prev, sl_prev;
  logic [BYTE_W-1:0]      shreg;
  logic [CNT_W-1:0]       nbits;
  logic [5:0]             bank [4];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      sc_q    <= '0;
      sd_q    <= '0;
      sl_q    <= '1;
      sc_prev <= 1'b0;
      sl_prev <= 1'b1;
    end else begin
      sc_q    <= {sc_q[SYNC_STAGES-2:0], ser_clk};
      sd_q    <= {sd_q[SYNC_STAGES-2:0], ser_dat};
      sl_q    <= {sl_q[SYNC_STAGES-2:0], ser_latch_n};
      sc_prev <= sc_q[SYNC_STAGES-1];
      sl_prev <= sl_q[SYNC_STAGES-1];
    end
  end

  wire latch_cur  = sl_q[SYNC_STAGES-1];
  wire latch_rise = latch_cur & ~sl_prev;
  wire clk_rise   = sc_q[SYNC_STAGES-1] & ~sc_prev & ~latch_cur;
  wire full_byte  = (nbits == CNT_W'(BYTE_W));
  wire commit     = latch_rise & full_byte & ~conv_busy;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      shreg <= '0;
      nbits <= '0;
    end else if (latch_rise) begin
      nbits <= '0;
    end else if (clk_rise) begin
      shreg <= {shreg[BYTE_W-2:0], sd_q[SYNC_STAGES-1]};
      if (!full_byte) nbits <= nbits + 1'b1;
    end
  end

  localparam logic [23:0] DEFS = {DEF3, DEF2, DEF1, DEF0};

  for (genvar i = 0; i < 4; i++) begin : g_reg
    always_ff @(posedge clk or posedge arst) begin
      if (arst)
        bank[i] <= DEFS[6*i +: 6];
      else if (commit && shreg[1:0] == 2'(i))
        bank[i] <= shreg[7:2];
    end
  end

  assign cfg0 = bank[0];
  assign cfg1 = bank[1];
  assign cfg2 = bank[2];
  assign cfg3 = bank[3];

  wire [23:0] bank_flat = {cfg3, cfg2, cfg1, cfg0};

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (arst)
    latch_rise && conv_busy |=> $stable(bank_flat));

  assert_short_blocks_R5: assert property (@(posedge clk) disable iff (arst)
    latch_rise && nbits < CNT_W'(BYTE_W) |=> $stable(bank_flat));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (arst)
    !latch_rise |=> $stable(bank_flat));

  assert_one_target_R3: assert property (@(posedge clk) disable iff (arst)
    $countones({cfg3 != $past(cfg3), cfg2 != $past(cfg2),
                cfg1 != $past(cfg1), cfg0 != $past(cfg0)}) <= 1);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (arst)
    nbits <= CNT_W'(BYTE_W));

  assert_idle_no_count_R7: assert property (@(posedge clk) disable iff (arst)
    latch_cur && !latch_rise |=> $stable(nbits));

endmodule

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
  localparam logic [5:0] D0 = 6'h01, D1 = 6'h01, D2 = 6'h20, D3 = 6'h00;

  logic clk = 0, arst = 1, ser_clk = 0, ser_dat = 0, ser_latch_n = 1, conv_busy = 0;
  logic [5:0] cfg0, cfg1, cfg2, cfg3;
  int checks = 0, errors = 0;
  bit done = 0;

  cfg_serial_port u0 (.clk, .arst, .ser_clk, .ser_dat, .ser_latch_n, .conv_busy,
                      .cfg0, .cfg1, .cfg2, .cfg3);

  always #2.5 clk = ~clk;

  // behavioural reference
  logic qc[$], qd[$], ql[$];
  logic [5:0] m [4];
  logic [7:0] m_sh;
  int m_cnt;

  always @(posedge clk or posedge arst) begin
    if (arst) begin
      qc = '{0, 0, 0}; qd = '{0, 0, 0}; ql = '{1, 1, 1};
      m[0] = D0; m[1] = D1; m[2] = D2; m[3] = D3; m_sh = 0; m_cnt = 0;
    end else begin
      qc.push_back(ser_clk); qd.push_back(ser_dat); ql.push_back(ser_latch_n);
      if (ql[1] && !ql[0]) begin
        if (m_cnt >= 8 && !conv_busy) m[m_sh[1:0]] = m_sh[7:2];
        m_cnt = 0;
      end else if (!ql[1] && qc[1] && !qc[0]) begin
        m_sh = {m_sh[6:0], qd[1]};
        m_cnt++;
      end
      void'(qc.pop_front()); void'(qd.pop_front()); void'(ql.pop_front());
    end
  end

  always @(negedge clk) if (!arst && !done) begin
    checks++;
    if ({cfg3, cfg2, cfg1, cfg0} !== {m[3], m[2], m[1], m[0]}) begin
      errors++;
      $display("FAIL R8 cycle model: actual %h expected %h",
               {cfg3, cfg2, cfg1, cfg0}, {m[3], m[2], m[1], m[0]});
    end
  end

  task automatic expect_all(string req, logic [5:0] e0, e1, e2, e3);
    checks++;
    if ({cfg3, cfg2, cfg1, cfg0} !== {e3, e2, e1, e0}) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, {cfg3, cfg2, cfg1, cfg0}, {e3, e2, e1, e0});
    end
  endtask

  task automatic hold(int n); repeat (n) @(negedge clk); endtask

  task automatic shift_bits(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i]; hold(3);
      ser_clk = 1; hold(3);
      ser_clk = 0;
    end
  endtask

  task automatic xfer(logic [15:0] v, int n);
    ser_latch_n = 0; hold(4);
    shift_bits(v, n);
    hold(3);
    ser_latch_n = 1; hold(6);
  endtask

  initial begin
    logic [5:0] e [4];
    hold(3);
    expect_all("R1 reset", D0, D1, D2, D3);
    @(negedge clk) arst = 0; hold(2);
    expect_all("R1 after release", D0, D1, D2, D3);
    e[0] = D0; e[1] = D1; e[2] = D2; e[3] = D3;

    xfer({8'h0, 6'h2A, 2'd0}, 8); e[0] = 6'h2A;
    expect_all("R2 R3 write addr0", e[0], e[1], e[2], e[3]);
    xfer({8'h0, 6'h15, 2'd3}, 8); e[3] = 6'h15;
    expect_all("R3 write addr3", e[0], e[1], e[2], e[3]);
    xfer({8'h0, 6'h3F, 2'd2}, 8); e[2] = 6'h3F;
    expect_all("R3 write addr2", e[0], e[1], e[2], e[3]);
    xfer({8'h0, 6'h0C, 2'd1}, 8); e[1] = 6'h0C;
    expect_all("R2 write addr1", e[0], e[1], e[2], e[3]);

    xfer({5'b0, 3'b101, 6'h33, 2'd1}, 11); e[1] = 6'h33;
    expect_all("R4 last eight bits", e[0], e[1], e[2], e[3]);

    xfer({8'h0, 6'h3F, 2'd0}, 5);
    expect_all("R5 short transfer ignored", e[0], e[1], e[2], e[3]);
    xfer({8'h0, 6'h21, 2'd0}, 8); e[0] = 6'h21;
    expect_all("R5 full after short", e[0], e[1], e[2], e[3]);

    conv_busy = 1;
    xfer({8'h0, 6'h07, 2'd2}, 8);
    conv_busy = 0; hold(2);
    expect_all("R6 busy blocks", e[0], e[1], e[2], e[3]);

    ser_dat = 1;
    for (int k = 0; k < 6; k++) begin ser_clk = 1; hold(3); ser_clk = 0; hold(3); end
    xfer({8'h0, 5'b0, 3'b111}, 3);
    expect_all("R7 idle clocks not counted", e[0], e[1], e[2], e[3]);

    // R8 latency
    ser_latch_n = 0; hold(4);
    shift_bits({8'h0, 6'h2D, 2'd3}, 8); hold(3);
    ser_latch_n = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    expect_all("R8 not yet", e[0], e[1], e[2], e[3]);
    @(posedge clk); @(negedge clk); e[3] = 6'h2D;
    expect_all("R8 committed", e[0], e[1], e[2], e[3]);
    hold(4);

    @(negedge clk); #1 arst = 1; #0.5;
    expect_all("R1 asynchronous", D0, D1, D2, D3);
    hold(2); arst = 0; hold(3);
    expect_all("R1 held defaults", D0, D1, D2, D3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule